// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block sits in the audio sample path and scales a stereo pair of signed samples by a gain that changes gradually. Muting does not simply zero the output. When the active-low mute pin is pulled low, the gain walks down to zero, one step per sample, so the output fades to silence. When the pin is released, the gain walks back up to the programmed level at the same rate. A full swing between unity and silence takes 1024 sample periods.

The programmed attenuation setting is a linear gain code. 1024 means unity and 0 means silence. If the setting changes while the block is not muted, the gain moves to the new code at the same rate of one step per sample. If the mute pin changes while a ramp is in progress, the gain turns around from wherever it stands and never jumps. Both channels always share one gain. Each product is scaled by 1/1024, rounded toward minus infinity, and saturated to the sample width.

The block advances only on a one-cycle sample strobe. The mute pin is asynchronous, so it passes through a synchronizer before use. The current gain value is provided as an output so that the surrounding logic can observe the ramp.

Top module: `soft_mute_ramp`

## Requirements
- R1: While `rst_n` is low at a clock edge, `att_cur`, `dout_l` and `dout_r` are forced to 0. After reset the gain starts from 0.
- R2: The mute pin is active low and is resynchronized through `SYNC_STAGES` flops.
  - The pin must be steady for that many clocks before a strobe for the strobe to see the new level.
  - While the synchronized mute is low, the ramp target is 0.
  - While it is high, the ramp target is the programmed setting.
- R3: On each strobe, `att_cur` moves exactly one step toward its target, or holds if it already equals the target. Between strobes it does not change.
- R4: With the setting at 1024, a full ramp takes exactly 1024 strobes in each direction: from 0 up to 1024, and from 1024 down to 0.
- R5: Once the gain has reached 0, both outputs are exactly 0 for any input, including full-scale negative samples.
- R6: On a strobe, each output is registered as `floor(din * g / 1024)`, saturated to `DATA_W` bits.
  - `g` is the value `att_cur` held before that strobe's step.
  - The same `g` is used for both channels.
  - Outputs hold their value between strobes.
- R7: If mute is asserted or released in the middle of a ramp, the gain reverses direction from its current value without a jump.
- R8: A new setting applied while unmuted is approached at one step per strobe. Setting codes above 1024 are treated as 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe, once per sample period |
| mute_n | input | 1 | Asynchronous mute request, low = mute |
| att_set | input | GAIN_W+1 | Programmed linear gain code, 1024 = unity |
| din_l | input | DATA_W | Signed left input sample |
| din_r | input | DATA_W | Signed right input sample |
| dout_l | output | DATA_W | Signed scaled left sample |
| dout_r | output | DATA_W | Signed scaled right sample |
| att_cur | output | GAIN_W+1 | Gain code currently applied |

## Verification
Random samples are mixed with the most positive and most negative sample codes. The positive and negative extremes show whether rounding toward minus infinity is done correctly. They also show whether the two channels share one gain. Complete ramps are run from silence to unity and back, and the strobes are counted, to distinguish an exact 1024-sample slope from an off-by-one. A mute that is reversed partway down, and settings that move the target upward, downward and above unity, separate the turnaround behaviour and the clamping from a plain restart.

// File: rtl/soft_mute_pkg.sv
// Shared types for the soft mute ramp.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package soft_mute_pkg;

    // Direction the gain counter takes on the next sample strobe.
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;

endpackage

// File: rtl/smr_sync.sv
// Level synchronizer for an asynchronous control pin.
// Assumes the pin is a slow level; no pulse capture is attempted.
module smr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic flop_q;

            // Capture the pin in a single flop.
            always_ff @(posedge clk) begin
                if (!rst_n) flop_q <= RST_VAL;
                else        flop_q <= d;
            end

            assign q = flop_q;
        end else begin : g_chain
            logic [STAGES-1:0] pipe_q;

            // Shift the pin through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
                else        pipe_q <= {pipe_q[STAGES-2:0], d};
            end

            assign q = pipe_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/smr_ramp.sv
// Gain counter for the soft mute ramp.
// Moves one LSB per sample strobe toward a target that is zero while
// muted, or the clamped programmed code otherwise. Unity is 2**GAIN_W.
// Assumes mute_s is already synchronous to clk.
module smr_ramp
    import soft_mute_pkg::*;
#(
    parameter int GAIN_W = 10,
    localparam int CNT_W = GAIN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             mute_s,
    input  logic [CNT_W-1:0] att_set,
    output logic [CNT_W-1:0] gain_q
);

    localparam logic [CNT_W-1:0] UNITY = CNT_W'(1) << GAIN_W;

    logic [CNT_W-1:0] set_clamped;
    logic [CNT_W-1:0] target;
    ramp_dir_e        dir;

    // Clamp the programmed code to unity and pick the target from mute.
    always_comb begin
        set_clamped = (att_set > UNITY) ? UNITY : att_set;
        target      = mute_s ? set_clamped : '0;
    end

    // Decide which way the counter steps on the next strobe.
    always_comb begin
        if (gain_q < target)      dir = RAMP_UP;
        else if (gain_q > target) dir = RAMP_DOWN;
        else                      dir = RAMP_HOLD;
    end

    // Advance the gain counter by one step per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= '0;
        end else if (stb) begin
            unique case (dir)
                RAMP_UP:   gain_q <= gain_q + 1'b1;
                RAMP_DOWN: gain_q <= gain_q - 1'b1;
                default:   gain_q <= gain_q;
            endcase
        end
    end

    // R3
    gain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(gain_q));

    // R3
    gain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> ((gain_q == $past(gain_q)) ||
                 (gain_q == $past(gain_q) + 1'b1) ||
                 (gain_q == $past(gain_q) - 1'b1)));

    // R8
    gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_q <= UNITY);

    // R2
    mute_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !mute_s && gain_q != '0) |=> (gain_q == $past(gain_q) - 1'b1));

endmodule

// File: rtl/smr_scale.sv
// One channel of the gain multiply: out = sat(floor(din * gain / 2**GAIN_W)).
// Registers the result on the sample strobe and holds it otherwise.
// Assumes gain never exceeds 2**GAIN_W, but saturates regardless.
module smr_scale #(
    parameter int DATA_W = 18,
    parameter int GAIN_W = 10,
    localparam int CNT_W  = GAIN_W + 1,
    localparam int PROD_W = DATA_W + CNT_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stb,
    input  logic signed [DATA_W-1:0] din,
    input  logic        [CNT_W-1:0]  gain,
    output logic signed [DATA_W-1:0] dout
);

    localparam logic [CNT_W-1:0] UNITY = CNT_W'(1) << GAIN_W;
    localparam logic signed [PROD_W-1:0] SAT_HI =
        {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] SAT_LO =
        {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic signed [DATA_W-1:0] sat_val;

    // Multiply by the unsigned gain and drop the fraction toward minus infinity.
    always_comb begin
        prod    = PROD_W'(din) * $signed({1'b0, gain});
        shifted = prod >>> GAIN_W;
    end

    // Clip the scaled value into the sample range.
    always_comb begin
        if (shifted > SAT_HI)      sat_val = SAT_HI[DATA_W-1:0];
        else if (shifted < SAT_LO) sat_val = SAT_LO[DATA_W-1:0];
        else                       sat_val = shifted[DATA_W-1:0];
    end

    // Register the scaled sample once per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   dout <= '0;
        else if (stb) dout <= sat_val;
    end

    // R5
    zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && gain == '0) |=> (dout == '0));

    // R6
    unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && gain == UNITY) |=> (dout == $past(din)));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(dout));

endmodule

// File: rtl/soft_mute_ramp.sv
// Top of the soft mute ramp: synchronizes the mute pin, runs the shared
// gain counter and scales both channels with the pre-step gain.
// Assumes smp_stb is a single-cycle pulse, at most once per clock.
module soft_mute_ramp #(
    parameter int DATA_W      = 18,
    parameter int GAIN_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_stb,
    input  logic                     mute_n,
    input  logic [GAIN_W:0]          att_set,
    input  logic signed [DATA_W-1:0] din_l,
    input  logic signed [DATA_W-1:0] din_r,
    output logic signed [DATA_W-1:0] dout_l,
    output logic signed [DATA_W-1:0] dout_r,
    output logic [GAIN_W:0]          att_cur
);

    localparam int NUM_CH = 2;

    logic                     mute_s;
    logic [GAIN_W:0]          gain_q;
    logic signed [DATA_W-1:0] ch_in  [NUM_CH];
    logic signed [DATA_W-1:0] ch_out [NUM_CH];

    smr_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_mute_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (mute_n),
        .q     (mute_s)
    );

    smr_ramp #(
        .GAIN_W (GAIN_W)
    ) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (smp_stb),
        .mute_s  (mute_s),
        .att_set (att_set),
        .gain_q  (gain_q)
    );

    assign ch_in[0] = din_l;
    assign ch_in[1] = din_r;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            smr_scale #(
                .DATA_W (DATA_W),
                .GAIN_W (GAIN_W)
            ) u_scale (
                .clk   (clk),
                .rst_n (rst_n),
                .stb   (smp_stb),
                .din   (ch_in[ch]),
                .gain  (gain_q),
                .dout  (ch_out[ch])
            );
        end
    endgenerate

    assign dout_l  = ch_out[0];
    assign dout_r  = ch_out[1];
    assign att_cur = gain_q;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (att_cur == '0 && dout_l == '0 && dout_r == '0));

endmodule

// File: tb/soft_mute_ramp_test.sv
// Scoreboard bench for the soft mute ramp.
module soft_mute_ramp_test;

    localparam int DW = 18;
    localparam int GW = 10;
    localparam int UNITY = 1 << GW;
    localparam int MAXV = (1 << (DW-1)) - 1;
    localparam int MINV = -(1 << (DW-1));

    typedef struct {
        int    l;
        int    r;
        int    g;
        string tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_stb = 1'b0;
    logic                 mute_n = 1'b1;
    logic [GW:0]          att_set = '0;
    logic signed [DW-1:0] din_l = '0;
    logic signed [DW-1:0] din_r = '0;
    logic signed [DW-1:0] dout_l;
    logic signed [DW-1:0] dout_r;
    logic [GW:0]          att_cur;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    g_m     = 0;
    int    mute_m  = 1;
    int    set_m   = 0;
    string cur_tag = "R6";
    exp_t  sb_q[$];

    soft_mute_ramp #(.DATA_W(DW), .GAIN_W(GW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mute_n(mute_n),
        .att_set(att_set), .din_l(din_l), .din_r(din_r),
        .dout_l(dout_l), .dout_r(dout_r), .att_cur(att_cur)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int scale_ref(input int x, input int g);
        longint p;
        p = (longint'(x) * longint'(g)) >>> GW;
        if (p > MAXV) return MAXV;
        if (p < MINV) return MINV;
        return int'(p);
    endfunction

    // Driver: apply one sample strobe and push the expected result.
    task automatic send(input int l, input int r);
        exp_t e;
        int   tgt;
        @(negedge clk);
        din_l   = DW'(l);
        din_r   = DW'(r);
        smp_stb = 1'b1;
        e.l   = scale_ref(l, g_m);
        e.r   = scale_ref(r, g_m);
        tgt   = mute_m ? ((set_m > UNITY) ? UNITY : set_m) : 0;
        if (g_m < tgt) g_m++;
        else if (g_m > tgt) g_m--;
        e.g   = g_m;
        e.tag = cur_tag;
        sb_q.push_back(e);
        @(negedge clk);
        smp_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_rand();
        int l;
        int r;
        case ($urandom_range(0, 3))
            0:       begin l = MAXV; r = MINV; end
            1:       begin l = MINV; r = MAXV; end
            default: begin
                l = $urandom_range(0, (1 << DW) - 1) - (1 << (DW-1));
                r = $urandom_range(0, (1 << DW) - 1) - (1 << (DW-1));
            end
        endcase
        send(l, r);
    endtask

    task automatic set_ctrl(input int mute, input int setv);
        @(negedge clk);
        mute_n  = mute[0];
        att_set = (GW+1)'(setv);
        mute_m  = mute;
        set_m   = setv;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pop expected items as strobed results appear.
    initial begin
        forever begin
            @(posedge clk);
            if (smp_stb && rst_n) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R6 queue", 0, 1);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(int'(dout_l) == e.l, {e.tag, " left"}, int'(dout_l), e.l);
                    check(int'(dout_r) == e.r, {e.tag, " right"}, int'(dout_r), e.r);
                    check(int'(att_cur) == e.g, {e.tag, " gain"}, int'(att_cur), e.g);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int steps;
        int held;
        // R1: reset state
        mute_n  = 1'b1;
        att_set = (GW+1)'(UNITY);
        repeat (5) @(negedge clk);
        check(att_cur == '0, "R1 gain", int'(att_cur), 0);
        check(dout_l == '0 && dout_r == '0, "R1 out", int'(dout_l), 0);
        rst_n = 1'b1;
        set_ctrl(1, UNITY);

        // R4: ramp up from silence to unity
        cur_tag = "R4";
        steps = 0;
        while (int'(att_cur) < UNITY && steps < 2000) begin
            send_rand();
            steps++;
        end
        check(steps == 1024, "R4 up strobes", steps, 1024);

        // R6: unity gain with extremes and random data
        cur_tag = "R6";
        send(MAXV, MINV);
        send(MINV, MAXV);
        send(-1, 1);
        repeat (10) send_rand();

        // R3: no strobe, no change
        held = int'(att_cur);
        repeat (20) @(negedge clk);
        check(int'(att_cur) == held, "R3 idle gain", int'(att_cur), held);

        // R2/R4: mute ramp down to zero
        cur_tag = "R2";
        set_ctrl(0, UNITY);
        steps = 0;
        while (int'(att_cur) > 0 && steps < 2000) begin
            send_rand();
            steps++;
        end
        check(steps == 1024, "R4 down strobes", steps, 1024);

        // R5: silent output at zero gain
        cur_tag = "R5";
        send(MINV, MINV);
        send(MAXV, -1);
        repeat (10) send_rand();

        // R7: reverse mid ramp
        cur_tag = "R7";
        set_ctrl(1, UNITY);
        repeat (300) send_rand();
        set_ctrl(0, UNITY);
        repeat (100) send_rand();
        check(int'(att_cur) == 200, "R7 turnaround", int'(att_cur), 200);
        set_ctrl(1, UNITY);
        repeat (50) send_rand();
        check(int'(att_cur) == 250, "R7 re-rise", int'(att_cur), 250);

        // R8: clamp above unity, then move down to a lower setting
        cur_tag = "R8";
        set_ctrl(1, 2000);
        repeat (800) send_rand();
        check(int'(att_cur) == UNITY, "R8 clamp", int'(att_cur), UNITY);
        set_ctrl(1, 500);
        repeat (530) send_rand();
        check(int'(att_cur) == 500, "R8 lower set", int'(att_cur), 500);
        set_ctrl(1, 700);
        repeat (100) send_rand();
        check(int'(att_cur) == 600, "R8 rate", int'(att_cur), 600);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R6 drained", sb_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule